// File: doc/BRIEF.md
# Low-Power Clock Gating Sequencer

This block decides which clock domains of a small microcontroller system receive a clock as the system moves between its run state and its low-power states. It drives separate gate enables for the processor, the program Flash, the on-chip SRAM and the peripheral domain. It also drives the enables of the PLL and the crystal oscillator and the enable of the external clock output. A power controller outside the block requests a mode. A separate wakeup event ends the low-power period. The block never leaves a low-power mode on its own.

Leaving any low-power mode follows a fixed order. The oscillator is restarted first and the PLL relocked second, each only where it was switched off. The Flash clock then runs alone for a guaranteed warm-up period, so that the processor can fetch code as soon as its own clock returns. For stop mode, a 2-bit option decides which clock sources stay powered, which trades standby current against recovery time. A fast-wakeup input and an external-clock-mode input each skip the source waits. Per-domain local disable inputs let each module turn off its own clock on top of the global decision.

Top module: `lp_clk_sequencer`

## Requirements
- R1: During reset and right after it, all four domain enables, `pll_en`, `osc_en` and `clkout_en` are 1. This assumes `local_dis` is 0.
- R2: After a wait request (`mode_req`=001) or a doze request (`mode_req`=010) has been taken, the peripheral enable is 1 and the CPU, Flash and SRAM enables are 0. `pll_en`, `osc_en` and `clkout_en` stay 1.
- R3: After a stop request (`mode_req`=011) has been taken, all four domain enables are 0 until a wakeup arrives.
- R4: In stop, the option latched at entry sets the clock sources. Option 00 keeps the PLL and the oscillator on. Option 01 turns the PLL off and keeps the oscillator on. Options 10 and 11 turn both off. `pll_en` = 1 only for option 00, `osc_en` = 1 only for options 00 and 01, and `clkout_en` is 1 in stop exactly when the PLL stays on.
- R5: On every exit from a low-power mode, the Flash enable (and the peripheral enable) is 1 with the CPU enable at 0 for exactly `WARM_CYCLES` clock cycles (default 16). Only after that do the CPU and SRAM enables return to 1.
- R6: On a stop exit with options 10 or 11, the domain enables stay 0 until `osc_ready` is 1. They then stay 0 until `pll_lock` is 1. With option 01, only `pll_lock` is awaited. With option 00, the Flash warm-up starts one cycle after the wakeup.
- R7: When `fast_wake` is 1 at the wakeup, the Flash warm-up starts in the next cycle without waiting for `osc_ready` or `pll_lock`.
- R8: When `ext_clk_mode` is 1 at the wakeup, there is no oscillator wait and no PLL wait; the Flash warm-up starts in the next cycle.
- R9: A halted request (`mode_req`=100) or a run request (`mode_req`=000) keeps all enables at their run values. A `wake_evt` pulse in run has no effect.
- R10: A `wake_evt` pulse in the cycle after a low-power request is taken, while the mode is still being entered, is held. The block completes the entry and then leaves the mode one cycle later.
- R11: Each domain enable is the global decision ANDed with the inverse of its local disable bit. The bits are `local_dis[0]` CPU, `[1]` Flash, `[2]` SRAM and `[3]` peripheral.
- R12: During stop recovery (source waits and Flash warm-up), `clkout_en` is 0 for option 11 and 1 for every other option.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (free-running reference) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_req | input | 3 | Requested mode: 000 run, 001 wait, 010 doze, 011 stop, 100 halted |
| wake_evt | input | 1 | Wakeup event pulse that ends a low-power mode |
| stop_opt | input | 2 | Stop clock-source option, latched on stop entry |
| fast_wake | input | 1 | Skip source waits on stop exit |
| ext_clk_mode | input | 1 | System clocked externally; no source waits |
| osc_ready | input | 1 | Oscillator has restarted |
| pll_lock | input | 1 | PLL is locked |
| local_dis | input | 4 | Per-domain local clock disables |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| flash_clk_en | output | 1 | Flash clock gate enable |
| sram_clk_en | output | 1 | SRAM clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| pll_en | output | 1 | PLL power enable |
| osc_en | output | 1 | Oscillator power enable |
| clkout_en | output | 1 | External clock output enable |

## Verification
The bench uses the default `WARM_CYCLES` of 16. The warm-up counter therefore runs to its top value of 15 in a 5-bit register, and the exact 16-cycle Flash-only window is measured at the ports on exits from wait, doze and stop. All four stop options are reached, and the oscillator and PLL status inputs are held low, so each recovery wait can be seen to hold. Fast wakeup, external clock mode and a wakeup that lands during mode entry are each driven against an option that would otherwise stall.

// File: rtl/lpcs_pkg.sv
package lpcs_pkg;

  localparam int NUM_DOM = 4;
  localparam int DOM_CPU = 0;
  localparam int DOM_FLASH = 1;
  localparam int DOM_SRAM = 2;
  localparam int DOM_PERIPH = 3;

  typedef enum logic [2:0] {
    SQ_RUN        = 3'd0,
    SQ_ENTER      = 3'd1,
    SQ_LOWPWR     = 3'd2,
    SQ_OSC_WAIT   = 3'd3,
    SQ_PLL_WAIT   = 3'd4,
    SQ_FLASH_WARM = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    LPK_WAIT = 2'd0,
    LPK_DOZE = 2'd1,
    LPK_STOP = 2'd2
  } lp_kind_e;

  localparam logic [2:0] REQ_WAIT = 3'b001;
  localparam logic [2:0] REQ_DOZE = 3'b010;
  localparam logic [2:0] REQ_STOP = 3'b011;

  localparam logic [1:0] OPT_ALL_ON = 2'b00;
  localparam logic [1:0] OPT_PLL_OFF = 2'b01;
  localparam logic [1:0] OPT_NO_CLKOUT = 2'b11;

endpackage

// File: rtl/lpcs_warm_timer.sv
module lpcs_warm_timer #(
  parameter int WARM_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int CW = $clog2(WARM_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Counter advances only while warm-up runs, clears otherwise
  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    if (!run_i)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == LAST);

  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_cnt_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);

endmodule

// File: rtl/lpcs_fsm.sv
module lpcs_fsm
  import lpcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_req,
  input  logic       wake_evt,
  input  logic [1:0] stop_opt,
  input  logic       fast_wake,
  input  logic       ext_clk_mode,
  input  logic       osc_ready,
  input  logic       pll_lock,
  input  logic       warm_done,
  output seq_state_e state_o,
  output lp_kind_e   lp_kind_o,
  output logic [1:0] opt_o
);

  seq_state_e state_q, state_d;
  lp_kind_e   kind_q, kind_d;
  logic [1:0] opt_q, opt_d;
  logic       pend_q, pend_d;
  logic       wake;
  logic       skip_src;

  assign wake     = wake_evt || pend_q;
  assign skip_src = fast_wake || ext_clk_mode;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    opt_d   = opt_q;
    pend_d  = pend_q;
    case (state_q)
      SQ_RUN: begin
        pend_d = 1'b0;
        case (mode_req)
          REQ_WAIT: begin state_d = SQ_ENTER; kind_d = LPK_WAIT; end
          REQ_DOZE: begin state_d = SQ_ENTER; kind_d = LPK_DOZE; end
          REQ_STOP: begin state_d = SQ_ENTER; kind_d = LPK_STOP; opt_d = stop_opt; end
          default:  state_d = SQ_RUN;
        endcase
      end
      SQ_ENTER: begin
        state_d = SQ_LOWPWR;
        if (wake_evt) pend_d = 1'b1;
      end
      SQ_LOWPWR: begin
        if (wake) begin
          pend_d = 1'b0;
          if (kind_q != LPK_STOP || skip_src) state_d = SQ_FLASH_WARM;
          else if (opt_q[1])                  state_d = SQ_OSC_WAIT;
          else if (opt_q == OPT_PLL_OFF)      state_d = SQ_PLL_WAIT;
          else                                state_d = SQ_FLASH_WARM;
        end
      end
      SQ_OSC_WAIT:   if (osc_ready) state_d = SQ_PLL_WAIT;
      SQ_PLL_WAIT:   if (pll_lock)  state_d = SQ_FLASH_WARM;
      SQ_FLASH_WARM: if (warm_done) state_d = SQ_RUN;
      default:       state_d = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_RUN;
      kind_q  <= LPK_WAIT;
      opt_q   <= OPT_ALL_ON;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      opt_q   <= opt_d;
      pend_q  <= pend_d;
    end
  end

  assign state_o   = state_q;
  assign lp_kind_o = kind_q;
  assign opt_o     = opt_q;

  p_wake_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_ENTER && wake_evt) |=> (state_q == SQ_LOWPWR && pend_q));

  p_osc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_OSC_WAIT && !osc_ready) |=> state_q == SQ_OSC_WAIT);

  p_pll_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_PLL_WAIT && !pll_lock) |=> state_q == SQ_PLL_WAIT);

  p_skip_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_LOWPWR && wake_evt && skip_src) |=> state_q == SQ_FLASH_WARM);

  p_lowpwr_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_LOWPWR && !wake) |=> state_q == SQ_LOWPWR);

endmodule

// File: rtl/lpcs_gate_decode.sv
module lpcs_gate_decode
  import lpcs_pkg::*;
(
  input  seq_state_e         state_i,
  input  lp_kind_e           kind_i,
  input  logic [1:0]         opt_i,
  output logic [NUM_DOM-1:0] dom_o,
  output logic               pll_en_o,
  output logic               osc_en_o,
  output logic               clkout_en_o
);

  logic in_stop;
  logic no_clkout;

  assign in_stop   = (kind_i == LPK_STOP);
  assign no_clkout = in_stop && (opt_i == OPT_NO_CLKOUT);

  always_comb begin
    dom_o       = '1;
    pll_en_o    = 1'b1;
    osc_en_o    = 1'b1;
    clkout_en_o = 1'b1;
    case (state_i)
      SQ_LOWPWR: begin
        if (in_stop) begin
          dom_o       = '0;
          pll_en_o    = (opt_i == OPT_ALL_ON);
          osc_en_o    = !opt_i[1];
          clkout_en_o = (opt_i == OPT_ALL_ON);
        end else begin
          dom_o             = '0;
          dom_o[DOM_PERIPH] = 1'b1;
        end
      end
      SQ_OSC_WAIT, SQ_PLL_WAIT: begin
        dom_o       = '0;
        clkout_en_o = !no_clkout;
      end
      SQ_FLASH_WARM: begin
        dom_o             = '0;
        dom_o[DOM_FLASH]  = 1'b1;
        dom_o[DOM_PERIPH] = 1'b1;
        clkout_en_o       = !no_clkout;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lp_clk_sequencer.sv
module lp_clk_sequencer
  import lpcs_pkg::*;
#(
  parameter int WARM_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_req,
  input  logic       wake_evt,
  input  logic [1:0] stop_opt,
  input  logic       fast_wake,
  input  logic       ext_clk_mode,
  input  logic       osc_ready,
  input  logic       pll_lock,
  input  logic [3:0] local_dis,
  output logic       cpu_clk_en,
  output logic       flash_clk_en,
  output logic       sram_clk_en,
  output logic       periph_clk_en,
  output logic       pll_en,
  output logic       osc_en,
  output logic       clkout_en
);

  localparam int CW = $clog2(WARM_CYCLES + 1);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  seq_state_e         state;
  lp_kind_e           kind;
  logic [1:0]         opt;
  logic               warm_done;
  logic [NUM_DOM-1:0] dom_raw;
  logic [NUM_DOM-1:0] dom_en;

  // Reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lpcs_fsm i_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .mode_req     (mode_req),
    .wake_evt     (wake_evt),
    .stop_opt     (stop_opt),
    .fast_wake    (fast_wake),
    .ext_clk_mode (ext_clk_mode),
    .osc_ready    (osc_ready),
    .pll_lock     (pll_lock),
    .warm_done    (warm_done),
    .state_o      (state),
    .lp_kind_o    (kind),
    .opt_o        (opt)
  );

  lpcs_warm_timer #(.WARM_CYCLES(WARM_CYCLES)) i_warm (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (state == SQ_FLASH_WARM),
    .done_o (warm_done)
  );

  lpcs_gate_decode i_dec (
    .state_i     (state),
    .kind_i      (kind),
    .opt_i       (opt),
    .dom_o       (dom_raw),
    .pll_en_o    (pll_en),
    .osc_en_o    (osc_en),
    .clkout_en_o (clkout_en)
  );

  // Local disables gate each domain after the global decision
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_local
    assign dom_en[g] = dom_raw[g] & ~local_dis[g];
  end

  assign cpu_clk_en    = dom_en[DOM_CPU];
  assign flash_clk_en  = dom_en[DOM_FLASH];
  assign sram_clk_en   = dom_en[DOM_SRAM];
  assign periph_clk_en = dom_en[DOM_PERIPH];

  // Checker: consecutive cycles with Flash clocked and CPU gated
  logic [CW:0] flash_only_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flash_only_q <= '0;
    else if (dom_raw[DOM_FLASH] && !dom_raw[DOM_CPU])
      flash_only_q <= (&flash_only_q) ? flash_only_q : flash_only_q + 1'b1;
    else
      flash_only_q <= '0;
  end

  p_flash_before_cpu_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dom_raw[DOM_CPU] && !$past(dom_raw[DOM_CPU])) |-> flash_only_q >= (CW+1)'(WARM_CYCLES));

  p_stop_all_off_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == SQ_LOWPWR && kind == LPK_STOP) |-> dom_raw == '0);

  p_idle_periph_only_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == SQ_LOWPWR && kind != LPK_STOP) |-> (dom_raw[DOM_PERIPH] && !dom_raw[DOM_CPU]));

  p_clkout_follows_pll_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == SQ_LOWPWR && kind == LPK_STOP) |-> clkout_en == pll_en);

  always_comb begin
    p_local_and_r11: assert (!(cpu_clk_en && local_dis[DOM_CPU]) &&
                             !(periph_clk_en && local_dis[DOM_PERIPH]));
  end

endmodule

// File: tb/test_lp_clk_sequencer.sv
module test_lp_clk_sequencer;

  localparam int WARM = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_req;
  logic       wake_evt;
  logic [1:0] stop_opt;
  logic       fast_wake;
  logic       ext_clk_mode;
  logic       osc_ready;
  logic       pll_lock;
  logic [3:0] local_dis;
  logic       cpu_clk_en, flash_clk_en, sram_clk_en, periph_clk_en;
  logic       pll_en, osc_en, clkout_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lp_clk_sequencer #(.WARM_CYCLES(WARM)) i_lp_clk_sequencer (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .wake_evt(wake_evt),
    .stop_opt(stop_opt), .fast_wake(fast_wake), .ext_clk_mode(ext_clk_mode),
    .osc_ready(osc_ready), .pll_lock(pll_lock), .local_dis(local_dis),
    .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en),
    .sram_clk_en(sram_clk_en), .periph_clk_en(periph_clk_en),
    .pll_en(pll_en), .osc_en(osc_en), .clkout_en(clkout_en)
  );

  // {periph, sram, flash, cpu}
  function automatic logic [3:0] doms();
    return {periph_clk_en, sram_clk_en, flash_clk_en, cpu_clk_en};
  endfunction

  // {pll, osc, clkout}
  function automatic logic [2:0] srcs();
    return {pll_en, osc_en, clkout_en};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic enter_mode(logic [2:0] m);
    @(negedge clk) mode_req = m;
    @(negedge clk) mode_req = 3'b000;
    @(negedge clk);
  endtask

  task automatic pulse_wake();
    @(negedge clk) wake_evt = 1'b1;
    @(negedge clk) wake_evt = 1'b0;
  endtask

  // Called at the negedge of the first warm-up cycle
  task automatic measure_warm(string req);
    int n = 0;
    while (flash_clk_en && !cpu_clk_en && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk({req, " flash-only cycles"}, n, WARM);
    chk({req, " run restored"}, doms(), 4'hF);
  endtask

  task automatic t_reset();
    chk("R1 domains in reset", doms(), 4'hF);
    chk("R1 sources in reset", srcs(), 3'b111);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 domains after reset", doms(), 4'hF);
    chk("R1 sources after reset", srcs(), 3'b111);
  endtask

  task automatic t_halted();
    @(negedge clk) mode_req = 3'b100;
    repeat (4) @(negedge clk);
    chk("R9 halted domains", doms(), 4'hF);
    chk("R9 halted sources", srcs(), 3'b111);
    mode_req = 3'b000;
    pulse_wake();
    @(negedge clk);
    chk("R9 wake in run ignored", doms(), 4'hF);
  endtask

  task automatic t_idle(logic [2:0] m, string tag);
    enter_mode(m);
    repeat (3) @(negedge clk);
    chk({"R2 ", tag, " domains"}, doms(), 4'b1000);
    chk({"R2 ", tag, " sources"}, srcs(), 3'b111);
    pulse_wake();
    chk({"R5 ", tag, " warm start"}, doms(), 4'b1010);
    measure_warm({"R5 ", tag});
  endtask

  task automatic t_stop_opt(logic [1:0] opt, logic [2:0] exp_src);
    stop_opt = opt;
    enter_mode(3'b011);
    stop_opt = 2'b00;
    repeat (2) @(negedge clk);
    chk("R3 stop domains off", doms(), 4'h0);
    chk("R4 stop source enables", srcs(), exp_src);
    fast_wake = 1'b1;
    osc_ready = 1'b0;
    pll_lock = 1'b0;
    pulse_wake();
    fast_wake = 1'b0;
    chk("R7 fast wake warm start", doms(), 4'b1010);
    chk("R12 clkout in recovery", clkout_en, (opt == 2'b11) ? 0 : 1);
    osc_ready = 1'b1;
    pll_lock = 1'b1;
    measure_warm("R5 stop fast");
  endtask

  task automatic t_stop_waits();
    stop_opt = 2'b10;
    osc_ready = 1'b0;
    pll_lock = 1'b0;
    enter_mode(3'b011);
    pulse_wake();
    repeat (4) @(negedge clk);
    chk("R6 osc wait domains off", doms(), 4'h0);
    chk("R12 clkout opt10 recovery", clkout_en, 1);
    osc_ready = 1'b1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 pll wait domains off", doms(), 4'h0);
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R6 warm after lock", doms(), 4'b1010);
    measure_warm("R5 stop opt10");
    // Option 01: only the lock is awaited
    stop_opt = 2'b01;
    pll_lock = 1'b0;
    enter_mode(3'b011);
    pulse_wake();
    repeat (2) @(negedge clk);
    chk("R6 opt01 waits lock", doms(), 4'h0);
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R6 opt01 warm after lock", doms(), 4'b1010);
    measure_warm("R5 stop opt01");
    // Option 00: straight to warm-up
    stop_opt = 2'b00;
    pll_lock = 1'b0;
    osc_ready = 1'b0;
    enter_mode(3'b011);
    pulse_wake();
    chk("R6 opt00 warm at once", doms(), 4'b1010);
    measure_warm("R5 stop opt00");
    osc_ready = 1'b1;
    pll_lock = 1'b1;
  endtask

  task automatic t_opt3_recovery();
    stop_opt = 2'b11;
    osc_ready = 1'b0;
    pll_lock = 1'b0;
    enter_mode(3'b011);
    pulse_wake();
    chk("R12 opt11 clkout low in osc wait", clkout_en, 0);
    osc_ready = 1'b1;
    pll_lock = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 opt11 clkout low in warm", clkout_en, 0);
    while (!cpu_clk_en) @(negedge clk);
    chk("R12 opt11 clkout back in run", clkout_en, 1);
  endtask

  task automatic t_ext_clk();
    stop_opt = 2'b10;
    osc_ready = 1'b0;
    pll_lock = 1'b0;
    ext_clk_mode = 1'b1;
    enter_mode(3'b011);
    pulse_wake();
    chk("R8 ext clock warm at once", doms(), 4'b1010);
    measure_warm("R8 ext clock");
    ext_clk_mode = 1'b0;
    osc_ready = 1'b1;
    pll_lock = 1'b1;
  endtask

  task automatic t_wake_latch();
    stop_opt = 2'b00;
    @(negedge clk) mode_req = 3'b011;
    @(negedge clk) begin mode_req = 3'b000; wake_evt = 1'b1; end
    @(negedge clk) wake_evt = 1'b0;
    chk("R10 entry completes", doms(), 4'h0);
    @(negedge clk);
    chk("R10 held wake exits", doms(), 4'b1010);
    measure_warm("R10 held wake");
  endtask

  task automatic t_local();
    @(negedge clk) local_dis = 4'b0101;
    #1 chk("R11 run with local disables", doms(), 4'b1010);
    @(negedge clk) local_dis = 4'b1000;
    #1 chk("R11 periph local disable", doms(), 4'b0111);
    enter_mode(3'b001);
    chk("R11 wait periph disabled", doms(), 4'b0000);
    @(negedge clk) local_dis = 4'b0000;
    #1 chk("R11 wait periph released", doms(), 4'b1000);
    pulse_wake();
    measure_warm("R11 exit");
  endtask

  initial begin
    rst_n = 1'b0;
    mode_req = 3'b000;
    wake_evt = 1'b0;
    stop_opt = 2'b00;
    fast_wake = 1'b0;
    ext_clk_mode = 1'b0;
    osc_ready = 1'b1;
    pll_lock = 1'b1;
    local_dis = 4'b0000;
    repeat (3) @(negedge clk);
    t_reset();
    t_halted();
    t_idle(3'b001, "wait");
    t_idle(3'b010, "doze");
    t_stop_opt(2'b00, 3'b111);
    t_stop_opt(2'b01, 3'b010);
    t_stop_opt(2'b10, 3'b000);
    t_stop_opt(2'b11, 3'b000);
    t_stop_waits();
    t_opt3_recovery();
    t_ext_clk();
    t_wake_latch();
    t_local();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule